// File: doc/BRIEF.md
# LPC Host I/O Cycle Engine

This block is the host end of a Low Pin Count bus, limited to I/O reads and I/O writes. A processor-side port presents a 16-bit I/O address, a byte count of 1, 2 or 4, up to 32 bits of write data and a one-clock start strobe. The request is accepted only if every byte it touches falls inside one of the programmable decode windows. An accepted request is carried out as one byte-wide bus cycle per byte, at ascending consecutive addresses. Each cycle places its nibbles on the four-bit LAD bus, framed by the active-low frame strobe. The engine waits through peripheral SYNC nibbles and collects read data nibble by nibble.

Read bytes are packed little-endian into a 32-bit result, which is presented with a single done pulse after the last byte cycle. A byte cycle that never receives a usable SYNC is aborted, and its read byte is replaced by all ones, as if no device had driven the bus. While the low-power input is held, the engine parks the bus: the frame strobe stays low and LAD is released.

Top module: `lpc_io_host`

## Requirements
- R1: An accepted request of N bytes (N = 1, 2 or 4) produces exactly N byte cycles, at addresses A, A+1, ... A+N-1 in that order.
- R2: Each byte cycle starts with exactly one clock of frame low with LAD = 0000. The direction nibble follows (0000 read, 0010 write), then the four address nibbles, most significant first. A write then sends its data byte, low nibble first.
- R3: After the host-driven part of a cycle, the host drives LAD = 1111 for one clock and then releases LAD (output enable low).
- R4: In SYNC, 0000 and 1010 mean ready and 0101 and 0110 mean wait. A wait nibble restarts the timeout count, so waits may last any number of clocks. Any other nibble counts toward the timeout, and after TMO_CLKS consecutive such clocks the cycle is aborted.
- R5: An abort drives frame low with LAD = 1111 for ABORT_CLKS clocks (default 4). A read byte from an aborted cycle returns FFh, and the next byte cycle, if any, still runs.
- R6: Read byte i of a request is returned in rdata[8i+7:8i], and bytes beyond the request are zero.
- R7: done is high for exactly one clock, once per accepted request, in the clock after the last byte cycle ends; busy is low in that clock.
- R8: A request whose bytes do not all lie inside one window [lo, hi], or whose count is not 1, 2 or 4, is refused. reqMiss pulses one clock later, and no bus cycle or done follows.
- R9: While lowPower is high and the engine is idle, the frame strobe is low, LAD is released, and start strobes are ignored.
- R10: After reset the frame strobe is high, LAD is released, and busy, done and reqMiss are low.
- R11: A start strobe that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqStart | input | 1 | One-clock request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | First I/O address |
| reqSize | input | 3 | Byte count (1, 2 or 4) |
| reqWdata | input | 32 | Write bytes, little-endian |
| winLo | input | 16*NWIN | Lower bound of each decode window |
| winHi | input | 16*NWIN | Upper bound of each decode window |
| lowPower | input | 1 | Park the bus |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| reqMiss | output | 1 | One-clock refusal pulse |
| rdata | output | 32 | Assembled read bytes |
| lframeN | output | 1 | Frame strobe, active low |
| ladOut | output | 4 | LAD value driven by the host |
| ladOe | output | 1 | LAD output enable |
| ladIn | input | 4 | LAD value seen on the bus |

## Verification
A wrong byte index or address register appears on the bus within a few clocks, as a wrong address nibble in the next byte cycle. It then shows up at done as bytes in the wrong lanes of rdata. A wrong sequencer state shows up as a missing or extra turnaround clock, or as a done pulse that comes early, late or twice. An error in the timeout counter only becomes visible at the ports in two cases. A long run of wait nibbles can end in a premature abort, or a silent bus can fail to abort, which leaves busy stuck high. The bench therefore drives waits longer than the timeout and a fully silent peripheral.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;
  localparam int ADDR_W = 16;
  localparam int NIB_N  = ADDR_W / 4;

  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_ERR   = 4'hA;
  localparam logic [3:0] SYNC_SWAIT = 4'h5;
  localparam logic [3:0] SYNC_LWAIT = 4'h6;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CTDIR, S_ADDR, S_WDATA, S_HTAR1, S_HTAR2,
    S_SYNC, S_RDATA, S_PTAR, S_ABORT
  } stateT;

  typedef enum logic [2:0] {
    NK_ZERO, NK_TYPE, NK_ADDR, NK_DLO, NK_DHI, NK_ONES
  } nibKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    capLo;
    logic    capHi;
    logic    capAbort;
    logic    nextByte;
    nibKindT nibKind;
    logic [1:0] nibIdx;
  } dpCtlT;
endpackage

// File: rtl/lpc_io_decode.sv
module lpc_io_decode #(
  parameter int NWIN = 2
) (
  input  logic [15:0]        addr,
  input  logic [2:0]         size,
  input  logic [NWIN*16-1:0] winLo,
  input  logic [NWIN*16-1:0] winHi,
  output logic               hit
);
  logic sizeOk;
  logic [16:0] lastAddr;
  logic [NWIN-1:0] winHit;

  assign sizeOk   = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
  assign lastAddr = {1'b0, addr} + {14'd0, size} - 17'd1;

  for (genvar g = 0; g < NWIN; g++) begin : gWin
    assign winHit[g] = (addr >= winLo[g*16 +: 16]) &&
                       (lastAddr <= {1'b0, winHi[g*16 +: 16]});
  end

  assign hit = sizeOk && (|winHit);
endmodule

// File: rtl/lpc_io_dpath.sv
module lpc_io_dpath
  import lpc_io_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCtlT       ctl,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [2:0]  reqSize,
  input  logic [31:0] reqWdata,
  input  logic [3:0]  ladIn,
  output logic        isWrite,
  output logic        lastByte,
  output logic [3:0]  ladOut,
  output logic [31:0] rdata
);
  logic [15:0] baseAddr;
  logic [15:0] byteAddr;
  logic [31:0] wReg;
  logic [31:0] rAcc;
  logic [2:0]  nBytes;
  logic [1:0]  byteIdx;
  logic [7:0]  wByte;

  assign byteAddr = baseAddr + {14'd0, byteIdx};
  assign wByte    = wReg[{byteIdx, 3'b000} +: 8];
  assign lastByte = ({1'b0, byteIdx} == (nBytes - 3'd1));
  assign rdata    = rAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      wReg     <= '0;
      rAcc     <= '0;
      nBytes   <= 3'd1;
      byteIdx  <= '0;
      isWrite  <= 1'b0;
    end else if (ctl.load) begin
      baseAddr <= reqAddr;
      wReg     <= reqWdata;
      rAcc     <= '0;
      nBytes   <= reqSize;
      byteIdx  <= '0;
      isWrite  <= reqWrite;
    end else begin
      if (ctl.capLo)    rAcc[{byteIdx, 3'b000} +: 4] <= ladIn;
      if (ctl.capHi)    rAcc[{byteIdx, 3'b100} +: 4] <= ladIn;
      if (ctl.capAbort) rAcc[{byteIdx, 3'b000} +: 8] <= 8'hFF;
      if (ctl.nextByte) byteIdx <= byteIdx + 2'd1;
    end
  end

  always_comb begin
    case (ctl.nibKind)
      NK_ZERO: ladOut = 4'h0;
      NK_TYPE: ladOut = {2'b00, isWrite, 1'b0};
      NK_ADDR: ladOut = byteAddr[{ctl.nibIdx, 2'b00} +: 4];
      NK_DLO:  ladOut = wByte[3:0];
      NK_DHI:  ladOut = wByte[7:4];
      default: ladOut = 4'hF;
    endcase
  end
endmodule

// File: rtl/lpc_io_ctrl.sv
module lpc_io_ctrl
  import lpc_io_pkg::*;
#(
  parameter int TMO_CLKS   = 8,
  parameter int ABORT_CLKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       lowPower,
  input  logic       hit,
  input  logic       isWrite,
  input  logic       lastByte,
  input  logic [3:0] ladIn,
  output dpCtlT      ctl,
  output logic       lframeN,
  output logic       ladOe,
  output logic       busy,
  output logic       done,
  output logic       reqMiss
);
  localparam int CNT_W = $clog2(ABORT_CLKS + NIB_N + 1);
  localparam int TMO_W = $clog2(TMO_CLKS + 1);

  stateT state;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tmo;
  logic accept, syncReady, syncWait, tmoHit, finish;

  assign accept    = (state == S_IDLE) && reqStart && !lowPower;
  assign syncReady = (ladIn == SYNC_READY) || (ladIn == SYNC_ERR);
  assign syncWait  = (ladIn == SYNC_SWAIT) || (ladIn == SYNC_LWAIT);
  assign tmoHit    = (state == S_SYNC) && !syncReady && !syncWait &&
                     (tmo == TMO_W'(TMO_CLKS - 1));
  assign finish    = ((state == S_PTAR) && (cnt == CNT_W'(1))) ||
                     ((state == S_ABORT) && (cnt == CNT_W'(ABORT_CLKS - 1)));

  always_comb begin
    ctl.load     = accept && hit;
    ctl.capLo    = (state == S_RDATA) && (cnt == '0);
    ctl.capHi    = (state == S_RDATA) && (cnt == CNT_W'(1));
    ctl.capAbort = tmoHit && !isWrite;
    ctl.nextByte = finish && !lastByte;
    ctl.nibIdx   = 2'(NIB_N - 1) - cnt[1:0];
    case (state)
      S_START: ctl.nibKind = NK_ZERO;
      S_CTDIR: ctl.nibKind = NK_TYPE;
      S_ADDR:  ctl.nibKind = NK_ADDR;
      S_WDATA: ctl.nibKind = (cnt == '0) ? NK_DLO : NK_DHI;
      default: ctl.nibKind = NK_ONES;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign lframeN = !((state == S_START) || (state == S_ABORT) ||
                     ((state == S_IDLE) && lowPower));
  assign ladOe   = (state == S_START) || (state == S_CTDIR) || (state == S_ADDR) ||
                   (state == S_WDATA) || (state == S_HTAR1) || (state == S_ABORT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      tmo     <= '0;
      done    <= 1'b0;
      reqMiss <= 1'b0;
    end else begin
      done    <= 1'b0;
      reqMiss <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (hit) state <= S_START;
          else     reqMiss <= 1'b1;
        end
        S_START: state <= S_CTDIR;
        S_CTDIR: begin state <= S_ADDR; cnt <= '0; end
        S_ADDR: if (cnt == CNT_W'(NIB_N - 1)) begin
          cnt   <= '0;
          state <= isWrite ? S_WDATA : S_HTAR1;
        end else cnt <= cnt + CNT_W'(1);
        S_WDATA: if (cnt == CNT_W'(1)) state <= S_HTAR1;
                 else cnt <= cnt + CNT_W'(1);
        S_HTAR1: state <= S_HTAR2;
        S_HTAR2: begin state <= S_SYNC; tmo <= '0; end
        S_SYNC: if (syncReady) begin
          cnt   <= '0;
          state <= isWrite ? S_PTAR : S_RDATA;
        end else if (syncWait) tmo <= '0;
        else if (tmoHit) begin
          cnt   <= '0;
          state <= S_ABORT;
        end else tmo <= tmo + TMO_W'(1);
        S_RDATA: if (cnt == CNT_W'(1)) begin
          cnt   <= '0;
          state <= S_PTAR;
        end else cnt <= cnt + CNT_W'(1);
        S_PTAR, S_ABORT: if (finish) begin
          cnt <= '0;
          if (lastByte) begin state <= S_IDLE; done <= 1'b1; end
          else state <= S_START;
        end else cnt <= cnt + CNT_W'(1);
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpc_io_host.sv
module lpc_io_host
  import lpc_io_pkg::*;
#(
  parameter int NWIN       = 2,
  parameter int TMO_CLKS   = 8,
  parameter int ABORT_CLKS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqStart,
  input  logic               reqWrite,
  input  logic [15:0]        reqAddr,
  input  logic [2:0]         reqSize,
  input  logic [31:0]        reqWdata,
  input  logic [NWIN*16-1:0] winLo,
  input  logic [NWIN*16-1:0] winHi,
  input  logic               lowPower,
  output logic               busy,
  output logic               done,
  output logic               reqMiss,
  output logic [31:0]        rdata,
  output logic               lframeN,
  output logic [3:0]         ladOut,
  output logic               ladOe,
  input  logic [3:0]         ladIn
);
  dpCtlT ctl;
  logic hit, isWrite, lastByte;

  lpc_io_decode #(.NWIN(NWIN)) u_dec (
    .addr(reqAddr), .size(reqSize), .winLo(winLo), .winHi(winHi), .hit(hit)
  );

  lpc_io_ctrl #(.TMO_CLKS(TMO_CLKS), .ABORT_CLKS(ABORT_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .lowPower(lowPower),
    .hit(hit), .isWrite(isWrite), .lastByte(lastByte), .ladIn(ladIn),
    .ctl(ctl), .lframeN(lframeN), .ladOe(ladOe), .busy(busy),
    .done(done), .reqMiss(reqMiss)
  );

  lpc_io_dpath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .ladIn(ladIn), .isWrite(isWrite), .lastByte(lastByte),
    .ladOut(ladOut), .rdata(rdata)
  );
endmodule

// File: rtl/lpc_io_chk.sv
module lpc_io_chk (
  input logic       clk,
  input logic       rstN,
  input logic       done,
  input logic       busy,
  input logic       reqMiss,
  input logic       lowPower,
  input logic       lframeN,
  input logic       ladOe,
  input logic [3:0] ladOut
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R3
  tar_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ladOe) |-> ($past(ladOut) == 4'hF));

  // R9
  park_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lowPower && !busy) |-> (!lframeN && !ladOe));

  // R8
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqMiss |-> !busy);

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lframeN && ladOe && (ladOut == 4'h0)) |=> lframeN);
endmodule

bind lpc_io_host lpc_io_chk u_chk (.*);

// File: tb/sim_lpc_io_host.sv
module sim_lpc_io_host;
  localparam int NWIN = 2;
  localparam int WIN  = 200;

  typedef struct packed {
    logic        wr;
    logic [2:0]  size;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [1:0]  mode;   // 0 ready, 1 ready-with-error, 2 silent
    logic [3:0]  waitN;
    logic [31:0] expRd;
  } vecT;

  localparam int NV = 8;
  localparam vecT VEC [NV] = '{
    '{1'b1, 3'd4, 16'h0060, 32'h44332211, 2'd0, 4'd0,  32'h0},
    '{1'b0, 3'd4, 16'h0060, 32'h0,        2'd0, 4'd12, 32'h44332211},
    '{1'b1, 3'd2, 16'h0064, 32'h0000BEEF, 2'd0, 4'd1,  32'h0},
    '{1'b0, 3'd2, 16'h0063, 32'h0,        2'd0, 4'd0,  32'h0000EF44},
    '{1'b0, 3'd1, 16'h02F9, 32'h0,        2'd1, 4'd2,  32'h000000A9},
    '{1'b0, 3'd2, 16'h02FE, 32'h0,        2'd2, 4'd0,  32'h0000FFFF},
    '{1'b1, 3'd1, 16'h0065, 32'h0000005A, 2'd2, 4'd0,  32'h0},
    '{1'b0, 3'd1, 16'h0065, 32'h0,        2'd0, 4'd3,  32'h000000BE}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStart = 1'b0, reqWrite = 1'b0, lowPower = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [2:0]  reqSize = 3'd1;
  logic [31:0] reqWdata = '0;
  logic [NWIN*16-1:0] winLo = {16'h02F8, 16'h0060};
  logic [NWIN*16-1:0] winHi = {16'h02FF, 16'h006F};
  logic busy, done, reqMiss, lframeN, ladOe;
  logic [31:0] rdata;
  logic [3:0] ladOut;
  logic [3:0] ladIn = 4'hF;

  int checks = 0, errors = 0;

  lpc_io_host #(.NWIN(NWIN)) u0 (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .winLo(winLo), .winHi(winHi), .lowPower(lowPower), .busy(busy),
    .done(done), .reqMiss(reqMiss), .rdata(rdata), .lframeN(lframeN),
    .ladOut(ladOut), .ladOe(ladOe), .ladIn(ladIn)
  );

  always #10 clk = ~clk;

  // bus monitor and peripheral model
  logic [7:0]  mem [16];
  logic [15:0] logAddr [8];
  logic [3:0]  logType [8];
  logic [7:0]  logData [8];
  int nLog = 0, pc = -1, tarGood = 0, abortRun = 0, abort4 = 0, abortBad = 0;
  logic tarArm = 1'b0, prevOe = 1'b0, pAct = 1'b0;
  int pk = 0;
  logic [1:0] pMode = 2'd0;
  logic [3:0] pWait = 4'd0;

  initial for (int i = 0; i < 16; i++) mem[i] = 8'hA0 + 8'(i);

  always @(negedge clk) begin
    int idx;
    if (!lframeN && ladOe && ladOut == 4'hF) abortRun++;
    else if (abortRun > 0) begin
      if (abortRun == 4) abort4++; else abortBad++;
      abortRun = 0;
    end
    if (!lframeN && ladOe && ladOut == 4'h0) begin
      pc = 0; nLog++; tarArm = 1'b0;
    end else if (pc >= 0 && nLog > 0 && nLog <= 8) begin
      pc++;
      idx = nLog - 1;
      if (pc == 1) logType[idx] = ladOut;
      if (pc >= 2 && pc <= 5) logAddr[idx] = {logAddr[idx][11:0], ladOut};
      if (logType[idx] == 4'h2 && pc == 6) logData[idx][3:0] = ladOut;
      if (logType[idx] == 4'h2 && pc == 7) logData[idx][7:4] = ladOut;
      if (pc == ((logType[idx] == 4'h2) ? 8 : 6))
        tarArm = ladOe && lframeN && (ladOut == 4'hF);
      if (pc == ((logType[idx] == 4'h2) ? 9 : 7)) begin
        if (tarArm && !ladOe) tarGood++;
        tarArm = 1'b0;
      end
    end
    // peripheral
    if (prevOe && !ladOe && lframeN) begin
      pk = 0; pAct = 1'b1; ladIn = 4'hF;
    end else if (pAct) begin
      pk++;
      idx = (nLog > 0) ? nLog - 1 : 0;
      if (!lframeN || pMode == 2'd2) begin
        ladIn = 4'hF;
        if (!lframeN) pAct = 1'b0;
      end else if (pk <= int'(pWait)) ladIn = pk[0] ? 4'h5 : 4'h6;
      else if (pk == int'(pWait) + 1) begin
        ladIn = (pMode == 2'd1) ? 4'hA : 4'h0;
        if (logType[idx] == 4'h2) mem[logAddr[idx][3:0]] = logData[idx];
      end else if (logType[idx] != 4'h2 && pk == int'(pWait) + 2)
        ladIn = mem[logAddr[idx][3:0]][3:0];
      else if (logType[idx] != 4'h2 && pk == int'(pWait) + 3)
        ladIn = mem[logAddr[idx][3:0]][7:4];
      else begin
        ladIn = 4'hF; pAct = 1'b0;
      end
    end
    prevOe = ladOe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int doneCnt, missCnt;
  logic [31:0] got;

  task automatic issue(input logic wr, input logic [2:0] sz, input logic [15:0] a,
                       input logic [31:0] wd, input logic [1:0] md, input logic [3:0] wn);
    @(negedge clk);
    reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = wd;
    pMode = md; pWait = wn;
    nLog = 0; pc = -1; tarGood = 0; abort4 = 0; abortBad = 0;
    doneCnt = 0; missCnt = 0; got = '0;
    reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    for (int c = 0; c < WIN; c++) begin
      if (done) begin doneCnt++; got = rdata; end
      if (reqMiss) missCnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 lframeN", 32'(lframeN), 32'd1);
    chk("R10 ladOe", 32'(ladOe), 32'd0);
    chk("R10 busy/done/miss", {29'd0, busy, done, reqMiss}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].wr, VEC[v].size, VEC[v].addr, VEC[v].wdata, VEC[v].mode, VEC[v].waitN);
      chk("R7 single done", 32'(doneCnt), 32'd1);
      chk("R1 byte cycle count", 32'(nLog), 32'(VEC[v].size));
      for (int b = 0; b < int'(VEC[v].size); b++) begin
        chk("R1 byte address", 32'(logAddr[b]), 32'(VEC[v].addr + 16'(b)));
        chk("R2 direction nibble", 32'(logType[b]), VEC[v].wr ? 32'd2 : 32'd0);
        if (VEC[v].wr)
          chk("R2 write data nibbles", 32'(logData[b]), 32'(VEC[v].wdata[8*b +: 8]));
      end
      chk("R3 turnaround", 32'(tarGood), 32'(VEC[v].size));
      if (!VEC[v].wr) chk("R6 R4 R5 read data", got, VEC[v].expRd);
      if (VEC[v].mode == 2'd2) begin
        chk("R5 abort length", 32'(abort4), 32'(VEC[v].size));
        chk("R5 abort bad length", 32'(abortBad), 32'd0);
      end else chk("R4 no abort", 32'(abort4 + abortBad), 32'd0);
    end

    // R8 out of window, crossing the upper bound, bad size
    issue(1'b0, 3'd1, 16'h0070, 32'h0, 2'd0, 4'd0);
    chk("R8 miss pulse", 32'(missCnt), 32'd1);
    chk("R8 no cycle", 32'(nLog + doneCnt), 32'd0);
    issue(1'b0, 3'd2, 16'h006F, 32'h0, 2'd0, 4'd0);
    chk("R8 crossing miss", 32'(missCnt), 32'd1);
    chk("R8 crossing no cycle", 32'(nLog + doneCnt), 32'd0);
    issue(1'b0, 3'd3, 16'h0060, 32'h0, 2'd0, 4'd0);
    chk("R8 bad size miss", 32'(missCnt), 32'd1);
    issue(1'b0, 3'd1, 16'h006F, 32'h0, 2'd0, 4'd0);
    chk("R8 top byte hit", {missCnt[15:0], doneCnt[15:0]}, 32'h0000_0001);
    chk("R6 top byte data", got, 32'h000000AF);

    // R11 second start while busy
    @(negedge clk);
    reqWrite = 1'b0; reqSize = 3'd1; reqAddr = 16'h0060; pMode = 2'd0; pWait = 4'd5;
    nLog = 0; pc = -1; doneCnt = 0;
    reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    repeat (3) @(negedge clk);
    reqAddr = 16'h02F8; reqSize = 3'd4; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    for (int c = 0; c < WIN; c++) begin
      if (done) doneCnt++;
      @(negedge clk);
    end
    chk("R11 one done", 32'(doneCnt), 32'd1);
    chk("R11 one byte cycle", 32'(nLog), 32'd1);
    chk("R11 address kept", 32'(logAddr[0]), 32'h0060);

    // R9 low power parks bus and ignores starts
    @(negedge clk);
    lowPower = 1'b1;
    @(negedge clk);
    chk("R9 frame low", 32'(lframeN), 32'd0);
    chk("R9 lad released", 32'(ladOe), 32'd0);
    issue(1'b0, 3'd1, 16'h0060, 32'h0, 2'd0, 4'd0);
    chk("R9 start ignored", 32'(nLog + doneCnt + missCnt), 32'd0);
    chk("R9 still parked", {30'd0, lframeN, ladOe}, 32'd0);
    lowPower = 1'b0;
    @(negedge clk);
    chk("R9 frame released", 32'(lframeN), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule